// File: doc/BRIEF.md
# Temperature-Indexed DAC Setpoint Controller

This block sets the codes for two current-sink DACs. It can take them from a small table indexed by temperature, or it can take them from a host. In automatic mode, each conversion strobe brings a signed temperature word. The block turns that word into a table index in 2 °C steps, with the ends clamped. It then reads one table entry, which holds a code for each DAC, and loads both output registers on the same clock edge. Between strobes the codes hold.

A control bit switches the block to manual mode. In manual mode the block ignores the strobes, and the host writes each DAC register directly. The host can rewrite the table at any time. A changed entry is used from the next conversion that selects it.

Top module: `temp_dac_ctrl`

## Requirements
- R1: After reset, both DAC codes are 0 and the block is in automatic mode.
- R2: A host write with select code 0 sets the mode from data bit 1: 1 selects automatic mode and 0 selects manual mode. The other data bits have no effect. A host write with select code 3 has no effect.
- R3: In automatic mode, a clock edge with `temp_valid` high loads both codes from the selected table entry, and the new codes are visible after that edge. Without a strobe, both codes hold.
- R4: The integer temperature is the 16-bit word shifted right arithmetically by 8 (1/256 °C per LSB, rounded toward minus infinity). The index is floor((deg + 40) / 2), clamped to 0 for deg ≤ −40 and to 71 for deg ≥ 102.
- R5: A table entry write puts data bits 7:0 into the DAC0 code and bits 15:8 into the DAC1 code. Writes to addresses 72 and above are dropped. A table write on the same edge as a strobe is seen from the next strobe on.
- R6: In automatic mode, host writes with select code 1 or 2 leave both codes unchanged.
- R7: In manual mode, strobes leave both codes unchanged. A host write with select code 1 loads DAC0 and select code 2 loads DAC1, each visible after the edge.
- R8: Returning from manual to automatic mode keeps the manual codes until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_sample | input | 16 | Two's-complement temperature, left-justified, 1/256 °C per LSB |
| temp_valid | input | 1 | One-cycle strobe marking a finished conversion |
| host_we | input | 1 | Host register write enable |
| host_sel | input | 2 | Host register select: 0 control, 1 DAC0, 2 DAC1, 3 none |
| host_wdata | input | 8 | Host write data |
| lut_we | input | 1 | Table entry write enable |
| lut_waddr | input | 7 | Table entry address |
| lut_wdata | input | 16 | Table entry: DAC1 code in bits 15:8, DAC0 code in bits 7:0 |
| dac0_code | output | 8 | Code for DAC0 |
| dac1_code | output | 8 | Code for DAC1 |

## Verification
The assertions assume that every input is a known value once reset is released. They also assume that `temp_valid` is a single-cycle strobe, and that table and host writes happen only on edges the bench controls. The stimulus drives every input on the falling clock edge and holds all strobes and write enables low between operations, so each rising edge sees exactly one intended event. The one exception is a deliberate table write on the same edge as a strobe.

// File: rtl/tdac_pkg.sv
package tdac_pkg;
    localparam int DAC_W      = 8;
    localparam int NUM_DAC    = 2;
    localparam int TEMP_W     = 16;
    localparam int FRAC_BITS  = 8;
    localparam int LUT_DEPTH  = 72;
    localparam int IDX_W      = $clog2(LUT_DEPTH);
    localparam int LUT_AW     = 7;
    localparam int T_LOW_DEG  = -40;
    localparam int STEP_DEG   = 2;
    localparam int CTRL_AUTO_BIT = 1;
    localparam int SEL_W      = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_DAC0 = 2'd1,
        SEL_DAC1 = 2'd2,
        SEL_NONE = 2'd3
    } host_sel_e;

    typedef enum logic {
        MODE_MANUAL = 1'b0,
        MODE_AUTO   = 1'b1
    } mode_e;

    function automatic int floor_deg(input logic [TEMP_W-1:0] word);
        int full;
        full = int'($signed(word));
        return full >>> FRAC_BITS;
    endfunction
endpackage

// File: rtl/tdac_index.sv
module tdac_index
    import tdac_pkg::*;
#(
    parameter int TW    = TEMP_W,
    parameter int DEPTH = LUT_DEPTH,
    parameter int IW    = IDX_W,
    parameter int TLOW  = T_LOW_DEG,
    parameter int STEP  = STEP_DEG
) (
    input  logic [TW-1:0] temp_i,
    output logic [IW-1:0] idx_o
);
    localparam int LAST = DEPTH - 1;

    int deg;
    int offs;
    int quot;

    always_comb begin
        deg  = floor_deg(temp_i);
        offs = deg - TLOW;
        if (offs <= 0) begin
            quot = 0;
        end else begin
            quot = offs / STEP;
        end
        if (quot > LAST) begin
            quot = LAST;
        end
        idx_o = IW'(quot);
    end
endmodule

// File: rtl/tdac_lut.sv
module tdac_lut
    import tdac_pkg::*;
#(
    parameter int DEPTH = LUT_DEPTH,
    parameter int AW    = LUT_AW,
    parameter int IW    = IDX_W,
    parameter int EW    = NUM_DAC * DAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [EW-1:0] wdata_i,
    input  logic [IW-1:0] raddr_i,
    output logic [EW-1:0] rdata_o
);
    logic [EW-1:0] entry [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam logic [AW-1:0] MY_ADDR = AW'(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                entry[i] <= '0;
            end else if (we_i && (waddr_i == MY_ADDR)) begin
                entry[i] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (int'(raddr_i) == k) begin
                rdata_o = entry[k];
            end
        end
    end
endmodule

// File: rtl/tdac_outreg.sv
module tdac_outreg
    import tdac_pkg::*;
#(
    parameter int DW   = DAC_W,
    parameter int ND   = NUM_DAC,
    parameter int SW   = SEL_W,
    parameter int ABIT = CTRL_AUTO_BIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [ND*DW-1:0] table_i,
    input  logic             host_we_i,
    input  logic [SW-1:0]    host_sel_i,
    input  logic [DW-1:0]    host_wdata_i,
    output logic             auto_o,
    output logic [ND*DW-1:0] codes_o
);
    mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_AUTO;
        end else if (host_we_i && (host_sel_i == SW'(SEL_CTRL))) begin
            mode_q <= host_wdata_i[ABIT] ? MODE_AUTO : MODE_MANUAL;
        end
    end

    assign auto_o = (mode_q == MODE_AUTO);

    for (genvar ch = 0; ch < ND; ch++) begin : g_chan
        localparam int unsigned MY_SEL = 32'(int'(SEL_DAC0) + ch);
        logic [DW-1:0] code_q;
        logic          host_hit;

        assign host_hit = host_we_i && (32'(host_sel_i) == MY_SEL);

        always_ff @(posedge clk) begin
            if (rst) begin
                code_q <= '0;
            end else if (mode_q == MODE_AUTO) begin
                if (load_i) begin
                    code_q <= table_i[ch*DW +: DW];
                end
            end else if (host_hit) begin
                code_q <= host_wdata_i;
            end
        end

        assign codes_o[ch*DW +: DW] = code_q;
    end
endmodule

// File: rtl/temp_dac_ctrl.sv
module temp_dac_ctrl
    import tdac_pkg::*;
#(
    parameter int DW    = DAC_W,
    parameter int TW    = TEMP_W,
    parameter int DEPTH = LUT_DEPTH,
    parameter int AW    = LUT_AW,
    parameter int SW    = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] temp_sample,
    input  logic          temp_valid,
    input  logic          host_we,
    input  logic [SW-1:0] host_sel,
    input  logic [DW-1:0] host_wdata,
    input  logic          lut_we,
    input  logic [AW-1:0] lut_waddr,
    input  logic [2*DW-1:0] lut_wdata,
    output logic [DW-1:0] dac0_code,
    output logic [DW-1:0] dac1_code
);
    localparam int IW = $clog2(DEPTH);
    localparam int EW = 2 * DW;

    logic [IW-1:0] tbl_idx;
    logic [EW-1:0] tbl_rd;
    logic [EW-1:0] codes;
    logic          auto_mode;

    tdac_index #(
        .TW(TW), .DEPTH(DEPTH), .IW(IW), .TLOW(T_LOW_DEG), .STEP(STEP_DEG)
    ) u_index (
        .temp_i (temp_sample),
        .idx_o  (tbl_idx)
    );

    tdac_lut #(
        .DEPTH(DEPTH), .AW(AW), .IW(IW), .EW(EW)
    ) u_lut (
        .clk     (clk),
        .rst     (rst),
        .we_i    (lut_we),
        .waddr_i (lut_waddr),
        .wdata_i (lut_wdata),
        .raddr_i (tbl_idx),
        .rdata_o (tbl_rd)
    );

    tdac_outreg #(
        .DW(DW), .ND(2), .SW(SW), .ABIT(CTRL_AUTO_BIT)
    ) u_out (
        .clk          (clk),
        .rst          (rst),
        .load_i       (temp_valid),
        .table_i      (tbl_rd),
        .host_we_i    (host_we),
        .host_sel_i   (host_sel),
        .host_wdata_i (host_wdata),
        .auto_o       (auto_mode),
        .codes_o      (codes)
    );

    assign dac0_code = codes[DW-1:0];
    assign dac1_code = codes[EW-1:DW];
endmodule

// File: rtl/tdac_checker.sv
module tdac_checker
    import tdac_pkg::*;
#(
    parameter int DW    = DAC_W,
    parameter int TW    = TEMP_W,
    parameter int DEPTH = LUT_DEPTH,
    parameter int IW    = IDX_W,
    parameter int SW    = SEL_W
) (
    input logic          clk,
    input logic          rst,
    input logic [TW-1:0] temp_sample,
    input logic          temp_valid,
    input logic          host_we,
    input logic [SW-1:0] host_sel,
    input logic [DW-1:0] host_wdata,
    input logic [DW-1:0] dac0_code,
    input logic [DW-1:0] dac1_code,
    input logic [IW-1:0] tbl_idx,
    input logic [2*DW-1:0] tbl_rd,
    input logic          auto_mode
);
    logic dac_wr;
    assign dac_wr = host_we && ((host_sel == SW'(SEL_DAC0)) || (host_sel == SW'(SEL_DAC1)));

    a_r1_reset_state: assert property (@(posedge clk)
        $fell(rst) |-> (dac0_code == '0) && (dac1_code == '0) && auto_mode);

    a_r2_mode_bit: assert property (@(posedge clk) disable iff (rst)
        host_we && (host_sel == SW'(SEL_CTRL)) |=> auto_mode == $past(host_wdata[CTRL_AUTO_BIT]));

    a_r3_auto_load: assert property (@(posedge clk) disable iff (rst)
        auto_mode && temp_valid |=> {dac1_code, dac0_code} == $past(tbl_rd));

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !temp_valid && !dac_wr |=> $stable(dac0_code) && $stable(dac1_code));

    a_r4_index_range: assert property (@(posedge clk) disable iff (rst)
        int'(tbl_idx) <= DEPTH - 1);

    a_r4_low_clamp: assert property (@(posedge clk) disable iff (rst)
        floor_deg(temp_sample) <= T_LOW_DEG |-> tbl_idx == '0);

    a_r6_auto_ignores_host: assert property (@(posedge clk) disable iff (rst)
        auto_mode && !temp_valid |=> $stable(dac0_code) && $stable(dac1_code));

    a_r7_manual_ignores_strobe: assert property (@(posedge clk) disable iff (rst)
        !auto_mode && !dac_wr |=> $stable(dac0_code) && $stable(dac1_code));

    a_r7_manual_write0: assert property (@(posedge clk) disable iff (rst)
        !auto_mode && host_we && (host_sel == SW'(SEL_DAC0)) |=> dac0_code == $past(host_wdata));
endmodule

bind temp_dac_ctrl tdac_checker #(
    .DW(DW), .TW(TW), .DEPTH(DEPTH), .IW(IW), .SW(SW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .temp_sample (temp_sample),
    .temp_valid  (temp_valid),
    .host_we     (host_we),
    .host_sel    (host_sel),
    .host_wdata  (host_wdata),
    .dac0_code   (dac0_code),
    .dac1_code   (dac1_code),
    .tbl_idx     (tbl_idx),
    .tbl_rd      (tbl_rd),
    .auto_mode   (auto_mode)
);

// File: tb/temp_dac_ctrl_bench.sv
module temp_dac_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] temp_sample = '0;
    logic        temp_valid = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic        lut_we = 1'b0;
    logic [6:0]  lut_waddr = '0;
    logic [15:0] lut_wdata = '0;
    logic [7:0]  dac0_code;
    logic [7:0]  dac1_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] m0 [72];
    logic [7:0] m1 [72];

    always #(CLK_PERIOD/2) clk = ~clk;

    temp_dac_ctrl u_temp_dac_ctrl (
        .clk(clk), .rst(rst), .temp_sample(temp_sample), .temp_valid(temp_valid),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .lut_we(lut_we), .lut_waddr(lut_waddr), .lut_wdata(lut_wdata),
        .dac0_code(dac0_code), .dac1_code(dac1_code)
    );

    function automatic int exp_index(input int deg);
        int q;
        if (deg + 40 <= 0) return 0;
        q = (deg + 40) / 2;
        return (q > 71) ? 71 : q;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [15:0] t);
        @(negedge clk);
        temp_sample = t;
        temp_valid  = 1'b1;
        @(negedge clk);
        temp_valid  = 1'b0;
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic lut_write(input int a, input logic [7:0] d0, input logic [7:0] d1);
        @(negedge clk);
        lut_we = 1'b1; lut_waddr = 7'(a); lut_wdata = {d1, d0};
        @(negedge clk);
        lut_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset values
        check(dac0_code, 8'h00, "R1 dac0 reset");
        check(dac1_code, 8'h00, "R1 dac1 reset");
        // R1: automatic mode out of reset -> a strobe loads entry (all zero table, write one first)
        lut_write(0, 8'h11, 8'h22);
        strobe(16'(-50 * 256));
        check(dac0_code, 8'h11, "R1 auto after reset dac0");
        check(dac1_code, 8'h22, "R1 auto after reset dac1");

        // R5: fill table, field positions
        for (int i = 0; i < 72; i++) begin
            m0[i] = 8'((i * 7 + 3) & 255);
            m1[i] = 8'((200 - i * 3) & 255);
            lut_write(i, m0[i], m1[i]);
        end
        // R5: out-of-range addresses dropped
        lut_write(72, 8'hEE, 8'hEE);
        lut_write(100, 8'hEE, 8'hEE);
        lut_write(127, 8'hEE, 8'hEE);

        // R3 / R4: sweep every integer degree with a varied fraction
        for (int d = -128; d < 128; d++) begin
            logic [15:0] w;
            int ix;
            w = 16'((d * 256) + ((d * 37) & 255));
            ix = exp_index(d);
            strobe(w);
            check(dac0_code, m0[ix], "R4 index sweep dac0");
            check(dac1_code, m1[ix], "R4 index sweep dac1");
        end
        // R4: boundaries
        strobe(16'(-40 * 256));
        check(dac0_code, m0[0], "R4 -40 clamp");
        strobe(16'(-39 * 256 - 1));
        check(dac0_code, m0[0], "R4 just below -39");
        strobe(16'(-38 * 256));
        check(dac0_code, m0[1], "R4 -38 step");
        strobe(16'(101 * 256 + 255));
        check(dac0_code, m0[70], "R4 101.99");
        strobe(16'(102 * 256));
        check(dac1_code, m1[71], "R4 102 clamp");

        // R3: hold without strobe
        strobe(16'(25 * 256));
        @(negedge clk);
        temp_sample = 16'(90 * 256);
        repeat (3) @(negedge clk);
        check(dac0_code, m0[32], "R3 hold dac0");
        check(dac1_code, m1[32], "R3 hold dac1");

        // R6: host DAC writes ignored in automatic mode
        host_write(2'd1, 8'hAA);
        host_write(2'd2, 8'h55);
        check(dac0_code, m0[32], "R6 ignore dac0 write");
        check(dac1_code, m1[32], "R6 ignore dac1 write");

        // R2: bit 1 clear (other bits set) -> manual
        host_write(2'd0, 8'hFD);
        strobe(16'(-20 * 256));
        check(dac0_code, m0[32], "R2 manual via bit1 / R7 strobe ignored");
        check(dac1_code, m1[32], "R7 strobe ignored dac1");

        // R7: manual writes
        host_write(2'd1, 8'h5A);
        check(dac0_code, 8'h5A, "R7 manual dac0");
        check(dac1_code, m1[32], "R7 dac1 untouched");
        host_write(2'd2, 8'hC3);
        check(dac1_code, 8'hC3, "R7 manual dac1");
        check(dac0_code, 8'h5A, "R7 dac0 untouched");
        // R2: select code 3 no effect
        host_write(2'd3, 8'hFF);
        strobe(16'(0));
        check(dac0_code, 8'h5A, "R2 sel3 no effect");
        check(dac1_code, 8'hC3, "R2 sel3 no effect dac1");

        // R8: back to auto keeps manual codes
        host_write(2'd0, 8'h02);
        repeat (2) @(negedge clk);
        check(dac0_code, 8'h5A, "R8 keep dac0");
        check(dac1_code, 8'hC3, "R8 keep dac1");

        // R5: table write on same edge as strobe -> old entry now, new next time
        @(negedge clk);
        temp_sample = 16'(60 * 256);
        temp_valid = 1'b1;
        lut_we = 1'b1; lut_waddr = 7'd50; lut_wdata = 16'h9876;
        @(negedge clk);
        temp_valid = 1'b0; lut_we = 1'b0;
        check(dac0_code, m0[50], "R5 same-edge old dac0");
        check(dac1_code, m1[50], "R5 same-edge old dac1");
        strobe(16'(61 * 256));
        check(dac0_code, 8'h76, "R5 new entry dac0");
        check(dac1_code, 8'h98, "R5 new entry dac1");

        // R2: other bits ignored while bit1 set
        host_write(2'd0, 8'hFF);
        strobe(16'(-128 * 256));
        check(dac0_code, m0[0], "R2 auto with 0xFF");

        finish_run();
    end
endmodule